// File: doc/BRIEF.md
# Shift-Tolerant Nucleotide k-mer Matcher

This block holds a small table of reference k-mers, each a fixed-length string of nucleotide symbols. It tells whether a query k-mer lies within an edit budget of any stored entry. The budget covers symbol substitutions and also single insertions or deletions. To catch an insertion or deletion, every stored symbol is compared with the query symbol at its own column and with the query symbols one column to either side.

An entry's edit cost is taken as the smallest of three scores. The unshifted score is the number of mismatching columns. Each of the two one-column shifted alignments scores one plus its mismatches, and the column left uncovered at the end of a shifted alignment is not counted. A valid entry is a hit when its cost is at or below the threshold sent with the query. A threshold of zero therefore gives plain exact matching.

Software loads the reference entries one at a time through the write port. It then presents queries, each with a 2-bit threshold, and reads back a registered per-entry hit vector together with a combined hit flag.

Top module: `dna_edit_matcher`

## Requirements
- R1: Symbols are 2 bits: A=00, C=01, G=10, T=11. Symbol i of a word sits at bits [2i+1:2i], and symbol 0 is the first symbol of the string.
- R2: While wrEn is high at a clock edge, wrData and wrValid are stored into entry wrIdx. Other entries are left unchanged.
- R3: The unshifted score of an entry is the number of columns i where the entry symbol differs from query symbol i.
- R4: The left-shift score is 1 plus the mismatches of entry symbol i against query symbol i+1, for i from 0 to K-2. The right-shift score is 1 plus the mismatches of entry symbol i against query symbol i-1, for i from 1 to K-1. The entry cost is the minimum of the unshifted, left-shift and right-shift scores.
- R5: A valid entry is a hit exactly when its cost is at most qThresh (0 to 3). With qThresh of 0, only an identical entry is a hit.
- R6: An entry whose valid bit is clear never reports a hit, whatever its data. Reset clears every valid bit.
- R7: matchVec and anyMatch are updated at the clock edge where qValid is high, and resValid is high during the following cycle only. When qValid is low, matchVec and anyMatch keep their values.
- R8: anyMatch equals the OR of all bits of matchVec.
- R9: If a query and a write happen at the same edge, the query is evaluated against the table contents before that write.
- R10: After reset, resValid, matchVec and anyMatch are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one table entry |
| wrIdx | input | $clog2(NUM_ENTRIES) | Entry index to write |
| wrData | input | 2*KMER_LEN | k-mer to store |
| wrValid | input | 1 | Valid bit stored with the entry |
| qValid | input | 1 | Query strobe |
| qData | input | 2*KMER_LEN | Query k-mer |
| qThresh | input | 2 | Largest edit cost still counted as a hit |
| resValid | output | 1 | High for one cycle when a new result is presented |
| matchVec | output | NUM_ENTRIES | Per-entry hit bits from the last query |
| anyMatch | output | 1 | High when any entry hit on the last query |

## Verification
Every query result is registered at the same edge that samples qValid, so matchVec, anyMatch and resValid are due one edge after the strobe. The bench drives inputs on the falling edge, removes the strobe at the next falling edge, and checks the outputs at that moment. Writes take effect at their own edge. Hold behaviour is checked several idle cycles after a result, and the same-edge write-and-query case is checked at the edge of the query, followed by a fresh query one cycle later.

// File: rtl/dna_match_pkg.sv
package dna_match_pkg;

  // Nucleotide encoding used by every word in the table and the query
  typedef enum logic [1:0] {
    BASE_A = 2'b00,
    BASE_C = 2'b01,
    BASE_G = 2'b10,
    BASE_T = 2'b11
  } base_e;

  localparam int SYM_W = 2;
  localparam int THR_W = 2;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEntry;
    logic runQuery;
  } ctlStrobe_t;

endpackage

// File: rtl/dna_entry_score.sv
module dna_entry_score
  import dna_match_pkg::*;
#(
  parameter int KMER_LEN = 8,
  localparam int WORD_W  = SYM_W * KMER_LEN,
  localparam int COST_W  = $clog2(KMER_LEN + 2)
) (
  input  logic [WORD_W-1:0] entryWord,
  input  logic [WORD_W-1:0] queryWord,
  output logic [COST_W-1:0] cost
);

  logic [KMER_LEN-1:0] eqSame;
  logic [KMER_LEN-2:0] eqLeft;
  logic [KMER_LEN-2:0] eqRight;

  // Column comparators: same column and the two neighbouring columns
  for (genvar i = 0; i < KMER_LEN; i++) begin : gSame
    assign eqSame[i] = entryWord[SYM_W*i +: SYM_W] == queryWord[SYM_W*i +: SYM_W];
  end

  for (genvar i = 0; i < KMER_LEN - 1; i++) begin : gShift
    // entry symbol i against query symbol i+1
    assign eqLeft[i]  = entryWord[SYM_W*i +: SYM_W] == queryWord[SYM_W*(i+1) +: SYM_W];
    // entry symbol i+1 against query symbol i
    assign eqRight[i] = entryWord[SYM_W*(i+1) +: SYM_W] == queryWord[SYM_W*i +: SYM_W];
  end

  logic [COST_W-1:0] missSame, missLeft, missRight;
  logic [COST_W-1:0] costLeft, costRight, bestShift;

  always_comb begin
    missSame  = '0;
    missLeft  = '0;
    missRight = '0;
    for (int i = 0; i < KMER_LEN; i++) begin
      missSame = missSame + COST_W'(!eqSame[i]);
    end
    for (int i = 0; i < KMER_LEN - 1; i++) begin
      missLeft  = missLeft + COST_W'(!eqLeft[i]);
      missRight = missRight + COST_W'(!eqRight[i]);
    end
    costLeft  = missLeft + COST_W'(1);
    costRight = missRight + COST_W'(1);
    bestShift = (costLeft < costRight) ? costLeft : costRight;
    cost      = (missSame < bestShift) ? missSame : bestShift;
  end

endmodule

// File: rtl/dna_match_ctl.sv
module dna_match_ctl
  import dna_match_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       qValid,
  output ctlStrobe_t strobe,
  output logic       resValid
);

  assign strobe.loadEntry = wrEn;
  assign strobe.runQuery  = qValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= qValid;
  end

  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rstN)
    qValid |=> resValid) else $error("result not flagged"); // R7

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !qValid |=> !resValid) else $error("spurious result flag"); // R7

endmodule

// File: rtl/dna_match_datapath.sv
module dna_match_datapath
  import dna_match_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int KMER_LEN    = 8,
  localparam int WORD_W     = SYM_W * KMER_LEN,
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int COST_W     = $clog2(KMER_LEN + 2)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobe,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [WORD_W-1:0]      wrData,
  input  logic                   wrValid,
  input  logic [WORD_W-1:0]      qData,
  input  logic [THR_W-1:0]       qThresh,
  output logic [NUM_ENTRIES-1:0] matchVec,
  output logic                   anyMatch
);

  logic [WORD_W-1:0]      entryMem [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] validMem;
  logic [NUM_ENTRIES-1:0] hitNext;

  // Table storage; the write lands at the same edge a query samples the old contents
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validMem <= '0;
    end else if (strobe.loadEntry && (32'(wrIdx) < NUM_ENTRIES)) begin
      validMem[wrIdx] <= wrValid;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.loadEntry && (32'(wrIdx) < NUM_ENTRIES)) begin
      entryMem[wrIdx] <= wrData;
    end
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    logic [COST_W-1:0] entryCost;

    dna_entry_score #(.KMER_LEN(KMER_LEN)) uScore (
      .entryWord (entryMem[e]),
      .queryWord (qData),
      .cost      (entryCost)
    );

    assign hitNext[e] = validMem[e] && (entryCost <= COST_W'(qThresh));

    AST_INVALID_MISS: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.runQuery && !validMem[e]) |=> !matchVec[e]) else $error("invalid entry hit"); // R6

    AST_EXACT_HIT: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.runQuery && validMem[e] && (entryMem[e] == qData)) |=> matchVec[e])
      else $error("identical entry missed"); // R5
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchVec <= '0;
      anyMatch <= 1'b0;
    end else if (strobe.runQuery) begin
      matchVec <= hitNext;
      anyMatch <= |hitNext;
    end
  end

  AST_ANY_IS_OR: assert property (@(posedge clk) disable iff (!rstN)
    anyMatch == (|matchVec)) else $error("summary flag disagrees"); // R8

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.runQuery |=> ($stable(matchVec) && $stable(anyMatch))) else $error("result moved"); // R7

endmodule

// File: rtl/dna_edit_matcher.sv
module dna_edit_matcher
  import dna_match_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int KMER_LEN    = 8,
  localparam int WORD_W     = SYM_W * KMER_LEN,
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [IDX_W-1:0]       wrIdx,
  input  logic [WORD_W-1:0]      wrData,
  input  logic                   wrValid,
  input  logic                   qValid,
  input  logic [WORD_W-1:0]      qData,
  input  logic [THR_W-1:0]       qThresh,
  output logic                   resValid,
  output logic [NUM_ENTRIES-1:0] matchVec,
  output logic                   anyMatch
);

  ctlStrobe_t strobe;

  dna_match_ctl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .qValid   (qValid),
    .strobe   (strobe),
    .resValid (resValid)
  );

  dna_match_datapath #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .KMER_LEN    (KMER_LEN)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .wrValid  (wrValid),
    .qData    (qData),
    .qThresh  (qThresh),
    .matchVec (matchVec),
    .anyMatch (anyMatch)
  );

endmodule

// File: tb/tb_dna_edit_matcher.sv
module tb_dna_edit_matcher;

  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;
  localparam int KL = 8;

  typedef struct packed {
    logic [63:0]   qStr;
    logic [1:0]    thr;
    logic [NE-1:0] expVec;
  } vec_t;

  // Entries: 0=ACGTACGT 1=AAAACCCC 2=GGGGTTTT 3=TACGTACG 4=ACGTACGT (invalid)
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{"ACGTACGT", 2'd0, 8'h01},  // R3 exact
    '{"ACGTACGT", 2'd1, 8'h09},  // R4 right shift reaches entry 3
    '{"ACGTACGT", 2'd3, 8'h09},
    '{"ACGAACGT", 2'd0, 8'h00},  // R5 one substitution, threshold 0
    '{"ACGAACGT", 2'd1, 8'h01},
    '{"ACGAACGT", 2'd2, 8'h09},  // R4 shift plus substitution = 2
    '{"TACGTACG", 2'd0, 8'h08},
    '{"TACGTACG", 2'd1, 8'h09},  // R4 left shift reaches entry 0
    '{"CCCCCCCC", 2'd3, 8'h00},  // R5 cost 4 exceeds 3
    '{"AAACCCCC", 2'd0, 8'h00},
    '{"AAACCCCC", 2'd1, 8'h02}   // R5 cost equals threshold
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrIdx = '0;
  logic [2*KL-1:0] wrData = '0;
  logic wrValid = 1'b0;
  logic qValid = 1'b0;
  logic [2*KL-1:0] qData = '0;
  logic [1:0] qThresh = '0;
  logic resValid;
  logic [NE-1:0] matchVec;
  logic anyMatch;

  int testCount = 0;
  int failCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dna_edit_matcher #(.NUM_ENTRIES(NE), .KMER_LEN(KL)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .wrValid(wrValid), .qValid(qValid), .qData(qData), .qThresh(qThresh),
    .resValid(resValid), .matchVec(matchVec), .anyMatch(anyMatch)
  );

  // R1 encoding, leftmost character is symbol 0
  function automatic logic [2*KL-1:0] pk(input logic [63:0] s);
    logic [2*KL-1:0] w = '0;
    for (int j = 0; j < KL; j++) begin
      logic [7:0] c = s[63-8*j -: 8];
      case (c)
        "A": w[2*j +: 2] = 2'b00;
        "C": w[2*j +: 2] = 2'b01;
        "G": w[2*j +: 2] = 2'b10;
        default: w[2*j +: 2] = 2'b11;
      endcase
    end
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic writeEntry(input int idx, input logic [63:0] s, input logic v);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'(idx); wrData = pk(s); wrValid = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runQuery(input logic [63:0] s, input logic [1:0] t);
    @(negedge clk);
    qValid = 1'b1; qData = pk(s); qThresh = t;
    @(negedge clk);
    qValid = 1'b0;
  endtask

  task automatic checkResult(input string req, input logic [NE-1:0] exp);
    chk({req, " resValid"}, 32'(resValid), 32'd1);
    chk({req, " matchVec"}, 32'(matchVec), 32'(exp));
    chk({"R8 anyMatch"}, 32'(anyMatch), 32'(|exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 resValid", 32'(resValid), 32'd0);
    chk("R10 matchVec", 32'(matchVec), 32'd0);
    chk("R10 anyMatch", 32'(anyMatch), 32'd0);

    // R6 empty table: nothing valid after reset
    runQuery("ACGTACGT", 2'd3);
    checkResult("R6 empty", '0);

    // R2 load table
    writeEntry(0, "ACGTACGT", 1'b1);
    writeEntry(1, "AAAACCCC", 1'b1);
    writeEntry(2, "GGGGTTTT", 1'b1);
    writeEntry(3, "TACGTACG", 1'b1);
    writeEntry(4, "ACGTACGT", 1'b0);  // R6 data identical but invalid

    for (int v = 0; v < NV; v++) begin
      runQuery(VECS[v].qStr, VECS[v].thr);
      checkResult($sformatf("R5 vec%0d", v), VECS[v].expVec);
    end

    // R7 hold: results stay put while idle
    repeat (4) @(negedge clk);
    chk("R7 resValid idle", 32'(resValid), 32'd0);
    chk("R7 matchVec held", 32'(matchVec), 32'h02);
    chk("R7 anyMatch held", 32'(anyMatch), 32'd1);

    // R6 invalidate entry 0
    writeEntry(0, "ACGTACGT", 1'b0);
    runQuery("ACGTACGT", 2'd0);
    checkResult("R6 invalidated", 8'h00);

    // R9 write and query on the same edge
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd0; wrData = pk("ACGTACGT"); wrValid = 1'b1;
    qValid = 1'b1; qData = pk("ACGTACGT"); qThresh = 2'd0;
    @(negedge clk);
    wrEn = 1'b0; qValid = 1'b0;
    checkResult("R9 old contents", 8'h00);
    runQuery("ACGTACGT", 2'd0);
    checkResult("R2 new contents", 8'h01);

    // R2 overwrite touches only one entry
    writeEntry(1, "GGGGTTTT", 1'b1);
    runQuery("GGGGTTTT", 2'd0);
    checkResult("R2 overwrite", 8'h06);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule